// File: doc/BRIEF.md
# Byte Matrix Transpose Shuffle Network

This block turns a 16x16 matrix of 8-bit pixels on its side, so that a datapath built for rows can treat columns as rows. The matrix sits in a register bank. It is loaded either whole in one cycle or one 16-byte row per cycle. A start pulse then launches a fixed sequence of shuffle passes. A one-cycle done pulse marks the moment the transposed matrix is ready on the output.

The transpose is not built from a crossbar. A single interleave stage is applied several times. Consider the 256 bytes as one memory with an 8-bit address: bits 0-3 give the byte within a row and bits 4-7 give the row. Each pass rotates these address bits by one place, and four passes swap the column and row halves of the address. The passes alternate between two register banks, so a pass never overwrites data it still has to read.

A second mode works only on rows 0-3. In that mode the block transposes the four 4x4 tiles held side by side in those rows, and leaves rows 4-15 untouched. This mode is its own inverse, so the same operation that packs pixels for filtering also restores them afterwards.

Top module: `byte_tpose_net`

## Requirements
- R1: While rst_ni is low and after its release, busy_o and done_o are 0 and mat_o is all zero until a load occurs.
- R2: When idle, row_we_i writes row_i into row row_sel_i of the bank, and this is visible on mat_o in the next cycle. Byte c of row r sits at mat_o bits [(16r+c)*8 +: 8], and byte c of row_i sits at bits [c*8 +: 8].
- R3: When idle, mat_we_i replaces the whole matrix with mat_i, using the same byte layout. If both load strobes are high together, mat_we_i wins.
- R4: Loads presented while busy_o is high are ignored and do not change the result.
- R5: A start_i pulse seen while idle raises busy_o in the next cycle. busy_o then stays high for exactly 4 cycles. done_o is high for exactly one cycle, in the first cycle after busy_o falls, and the result is valid on mat_o in that cycle.
- R6: With quad_mode_i = 0 at start, the result holds at row r, byte c the byte that was loaded at row c, byte r, for every r and c.
- R7: Running the full transpose twice returns the original matrix.
- R8: With quad_mode_i = 1 at start, the result at row r, byte c, for r < 4, holds the input byte at row c mod 4, byte 4*(c div 4) + r. That is, address bits 0/4 and 1/5 are swapped. Rows 4-15 keep their contents throughout the run.
- R9: Running the quad mode twice returns the original matrix.
- R10: A start_i pulse seen while busy is ignored. quad_mode_i is sampled only when a start is accepted.
- R11: While idle with no load strobe, mat_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_we_i | input | 1 | Write one row into the bank |
| row_sel_i | input | 4 | Row index for row_we_i |
| row_i | input | 128 | Row data, byte c at bits [c*8 +: 8] |
| mat_we_i | input | 1 | Write the whole matrix |
| mat_i | input | 2048 | Matrix data, row r byte c at bits [(16r+c)*8 +: 8] |
| quad_mode_i | input | 1 | 0: full 16x16 transpose, 1: four 4x4 transposes in rows 0-3 |
| start_i | input | 1 | Launch the pass sequence |
| busy_o | output | 1 | Pass sequence running |
| done_o | output | 1 | One-cycle pulse, result valid |
| mat_o | output | 2048 | Current matrix, same layout as mat_i |

## Verification
A load is due on mat_o one cycle after the edge that captures it. After the edge that captures start, busy_o is high for the next four sampled cycles, and done_o and the finished matrix appear at the fourth edge after capture. The bench drives inputs and samples outputs on falling edges. It records the busy/done pair on each of the six falling edges that follow a start and compares this trace with the one the requirements fix. It reads the matrix exactly on the done cycle, then checks one cycle later that done has dropped. Loads and a second start are injected only on edges that fall inside the busy window, so their being ignored shows in the matrix read on the done cycle.

// File: rtl/tpose_pkg.sv
package tpose_pkg;
  parameter int unsigned LANE_W    = 8;
  parameter int unsigned ROW_BYTES = 16;

  localparam int unsigned NROWS     = ROW_BYTES;
  localparam int unsigned ROW_W     = LANE_W * ROW_BYTES;
  localparam int unsigned MAT_W     = ROW_W * NROWS;
  localparam int unsigned IDX_W     = $clog2(ROW_BYTES);
  localparam int unsigned ROW_SEL_W = $clog2(NROWS);
  // one pass rotates the address by one bit; log2(rows) passes swap halves
  localparam int unsigned STEP_N    = $clog2(ROW_BYTES);
  localparam int unsigned STEP_W    = (STEP_N > 1) ? $clog2(STEP_N) : 1;
  localparam int unsigned QUAD_ROWS = 4;

  typedef logic [LANE_W-1:0]        lane_t;
  typedef lane_t [ROW_BYTES-1:0]    row_t;
  typedef row_t  [NROWS-1:0]        mat_t;
  typedef row_t  [QUAD_ROWS-1:0]    quad_t;

  // Interleave elements of esz bytes taken from one half of x and y.
  // Element of x precedes element of y at every output position.
  function automatic row_t lane_merge(row_t x, row_t y, int unsigned esz, logic upper);
    row_t        o;
    int unsigned k;
    int unsigned src;
    int unsigned sb;
    for (int unsigned b = 0; b < ROW_BYTES; b++) begin
      k   = b / esz;
      src = (k >> 1) + (upper ? ROW_BYTES / (2 * esz) : 0);
      sb  = src * esz + (b % esz);
      o[b] = k[0] ? y[sb[IDX_W-1:0]] : x[sb[IDX_W-1:0]];
    end
    return o;
  endfunction
endpackage

// File: rtl/tpose_shuffle_pass.sv
module tpose_shuffle_pass
  import tpose_pkg::*;
(
  input  mat_t src_i,
  output mat_t dst_o
);
  localparam int unsigned HALF = NROWS / 2;

  // out row 2x / 2x+1: byte interleave of lower / upper halves of rows x and x+HALF
  for (genvar x = 0; x < HALF; x++) begin : g_pair
    assign dst_o[2*x]   = lane_merge(src_i[x], src_i[x+HALF], 1, 1'b0);
    assign dst_o[2*x+1] = lane_merge(src_i[x], src_i[x+HALF], 1, 1'b1);
  end
endmodule

// File: rtl/tpose_quad_stage.sv
module tpose_quad_stage
  import tpose_pkg::*;
#(
  parameter int unsigned STAGE = 0
) (
  input  quad_t src_i,
  output quad_t dst_o
);
  localparam int unsigned ESZ = 1 << STAGE;

  // even stages pair rows (0,1),(2,3); odd stages pair (0,2),(1,3)
  if (STAGE % 2 == 0) begin : g_adj
    assign dst_o[0] = lane_merge(src_i[0], src_i[1], ESZ, 1'b0);
    assign dst_o[1] = lane_merge(src_i[0], src_i[1], ESZ, 1'b1);
    assign dst_o[2] = lane_merge(src_i[2], src_i[3], ESZ, 1'b0);
    assign dst_o[3] = lane_merge(src_i[2], src_i[3], ESZ, 1'b1);
  end else begin : g_cross
    assign dst_o[0] = lane_merge(src_i[0], src_i[2], ESZ, 1'b0);
    assign dst_o[1] = lane_merge(src_i[0], src_i[2], ESZ, 1'b1);
    assign dst_o[2] = lane_merge(src_i[1], src_i[3], ESZ, 1'b0);
    assign dst_o[3] = lane_merge(src_i[1], src_i[3], ESZ, 1'b1);
  end
endmodule

// File: rtl/tpose_seq.sv
module tpose_seq
  import tpose_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEP_N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      step_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          step_o <= '0;
        end
      end else if (step_o == LAST) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        step_o <= '0;
      end else begin
        step_o <= step_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/byte_tpose_net.sv
module byte_tpose_net
  import tpose_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 row_we_i,
  input  logic [ROW_SEL_W-1:0] row_sel_i,
  input  logic [ROW_W-1:0]     row_i,
  input  logic                 mat_we_i,
  input  logic [MAT_W-1:0]     mat_i,
  input  logic                 quad_mode_i,
  input  logic                 start_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [MAT_W-1:0]     mat_o
);
  mat_t              bank_a_q, bank_b_q;
  mat_t              src, full_res, nxt;
  quad_t             quad_res [STEP_N];
  quad_t             quad_pick;
  logic [STEP_W-1:0] step;
  logic              mode_q;
  logic              odd_step;

  tpose_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .step_o (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  mode_q <= 1'b0;
    else if (start_i && !busy_o)  mode_q <= quad_mode_i;
  end

  // even steps read bank A and write B, odd steps the reverse
  assign odd_step = step[0];
  assign src      = odd_step ? bank_b_q : bank_a_q;

  tpose_shuffle_pass u_pass (
    .src_i(src),
    .dst_o(full_res)
  );

  for (genvar s = 0; s < STEP_N; s++) begin : g_quad
    tpose_quad_stage #(.STAGE(s)) u_stage (
      .src_i(src[QUAD_ROWS-1:0]),
      .dst_o(quad_res[s])
    );
  end

  assign quad_pick = quad_res[step];

  always_comb begin
    if (mode_q) begin
      nxt                  = src;
      nxt[QUAD_ROWS-1:0]   = quad_pick;
    end else begin
      nxt                  = full_res;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_a_q <= '0;
    end else if (busy_o) begin
      if (odd_step) bank_a_q <= nxt;
    end else if (mat_we_i) begin
      bank_a_q <= mat_i;
    end else if (row_we_i) begin
      bank_a_q[row_sel_i] <= row_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   bank_b_q <= '0;
    else if (busy_o && !odd_step)  bank_b_q <= nxt;
  end

  assign mat_o = bank_a_q;
endmodule

// File: rtl/tpose_chk.sv
module tpose_chk
  import tpose_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             row_we_i,
  input logic             mat_we_i,
  input logic             quad_mode_i,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [MAT_W-1:0] mat_o
);
  localparam int unsigned      CNT_W   = STEP_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STEP_N);

  logic [CNT_W-1:0] run_cnt;
  logic             mode_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt   <= '0;
      mode_seen <= 1'b0;
    end else begin
      run_cnt <= busy_o ? run_cnt + 1'b1 : '0;
      if (start_i && !busy_o) mode_seen <= quad_mode_i;
    end
  end

  // R5
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R5
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_cnt < CNT_MAX));
  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !row_we_i && !mat_we_i) |=> $stable(mat_o));
  // R8
  quad_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mode_seen) |=> $stable(mat_o[MAT_W-1:QUAD_ROWS*ROW_W]));
endmodule

bind byte_tpose_net tpose_chk u_tpose_chk (.*);

// File: tb/test_byte_tpose_net.sv
module test_byte_tpose_net;
  localparam int N  = 16;
  localparam int RW = N * 8;
  localparam int MW = N * RW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          row_we_i, mat_we_i, quad_mode_i, start_i;
  logic [3:0]    row_sel_i;
  logic [RW-1:0] row_i;
  logic [MW-1:0] mat_i;
  logic          busy_o, done_o;
  logic [MW-1:0] mat_o;

  always #5 clk_i = ~clk_i;

  byte_tpose_net i_byte_tpose_net (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] tr_full(input logic [MW-1:0] m);
    logic [MW-1:0] o;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        o[(r*N+c)*8 +: 8] = m[(c*N+r)*8 +: 8];
    return o;
  endfunction

  function automatic logic [MW-1:0] tr_quad(input logic [MW-1:0] m);
    logic [MW-1:0] o = m;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < N; c++)
        o[(r*N+c)*8 +: 8] = m[((c%4)*N + (c/4)*4 + r)*8 +: 8];
    return o;
  endfunction

  function automatic logic [MW-1:0] rnd_mat();
    logic [MW-1:0] m;
    for (int w = 0; w < MW/32; w++) m[w*32 +: 32] = $urandom;
    return m;
  endfunction

  task automatic load_mat(input logic [MW-1:0] m);
    @(negedge clk_i);
    mat_i = m; mat_we_i = 1'b1;
    @(negedge clk_i);
    mat_we_i = 1'b0;
  endtask

  // start captured at E0; samples on the six falling edges after it
  task automatic run_op(input bit mode, input bit disturb, input bit restart, output logic [MW-1:0] res);
    logic [11:0] trace = '0;
    @(negedge clk_i);
    start_i = 1'b1; quad_mode_i = mode;
    @(negedge clk_i);
    start_i = 1'b0;
    trace = {trace[9:0], busy_o, done_o};
    if (disturb) begin
      mat_we_i = 1'b1; mat_i = '1; row_we_i = 1'b1; row_sel_i = 4'd2; row_i = '0;
    end
    @(negedge clk_i);
    trace = {trace[9:0], busy_o, done_o};
    if (restart) begin start_i = 1'b1; quad_mode_i = !mode; end
    @(negedge clk_i);
    trace = {trace[9:0], busy_o, done_o};
    start_i = 1'b0;
    @(negedge clk_i);
    trace = {trace[9:0], busy_o, done_o};
    @(negedge clk_i);
    trace = {trace[9:0], busy_o, done_o};
    mat_we_i = 1'b0; row_we_i = 1'b0;
    res = mat_o;
    @(negedge clk_i);
    trace = {trace[9:0], busy_o, done_o};
    chk(trace == 12'hAA4, restart ? "R10 busy/done trace" : "R5 busy/done trace",
        MW'(trace), MW'(12'hAA4));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R5 watchdog act=hung exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] m, e, r1, r2;
    row_we_i = 0; mat_we_i = 0; start_i = 0; quad_mode_i = 0;
    row_sel_i = '0; row_i = '0; mat_i = '0;
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk(!busy_o && !done_o && mat_o == '0, "R1 in reset", {busy_o, done_o, mat_o[MW-3:0]}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && mat_o == '0, "R1 after release", {busy_o, done_o, mat_o[MW-3:0]}, '0);

    // R2 row-by-row load
    for (int r = 0; r < N; r++) begin
      row_we_i = 1'b1; row_sel_i = 4'(r);
      for (int c = 0; c < N; c++) begin
        row_i[c*8 +: 8] = 8'((r*N + c) ^ 8'h5A);
        e[(r*N+c)*8 +: 8] = 8'((r*N + c) ^ 8'h5A);
      end
      @(negedge clk_i);
      chk(mat_o[r*RW +: RW] == row_i, "R2 row write", MW'(mat_o[r*RW +: RW]), MW'(row_i));
    end
    row_we_i = 1'b0;
    chk(mat_o == e, "R2 full bank", mat_o, e);

    // R3 matrix load wins over row load
    m = rnd_mat();
    mat_i = m; mat_we_i = 1'b1; row_we_i = 1'b1; row_sel_i = 4'd3; row_i = '1;
    @(negedge clk_i);
    mat_we_i = 1'b0; row_we_i = 1'b0;
    chk(mat_o == m, "R3 matrix load priority", mat_o, m);

    // R11 idle hold
    repeat (5) @(negedge clk_i);
    chk(mat_o == m, "R11 idle hold", mat_o, m);

    // R6 one-hot sweep over all 256 positions
    for (int a = 0; a < N*N; a++) begin
      m = '0; m[a*8 +: 8] = 8'(a) | 8'h01;
      load_mat(m);
      run_op(1'b0, 1'b0, 1'b0, r1);
      chk(r1 == tr_full(m), "R6 one-hot full", r1, tr_full(m));
    end

    // R6 address pattern
    for (int a = 0; a < N*N; a++) m[a*8 +: 8] = 8'(a);
    load_mat(m);
    run_op(1'b0, 1'b0, 1'b0, r1);
    chk(r1 == tr_full(m), "R6 address pattern", r1, tr_full(m));

    // R6 / R7 random data, transpose twice
    for (int t = 0; t < 8; t++) begin
      m = rnd_mat();
      load_mat(m);
      run_op(1'b0, 1'b0, 1'b0, r1);
      chk(r1 == tr_full(m), "R6 random full", r1, tr_full(m));
      run_op(1'b0, 1'b0, 1'b0, r2);
      chk(r2 == m, "R7 full twice", r2, m);
    end

    // R8 one-hot sweep over rows 0-3, random upper rows
    for (int a = 0; a < 4*N; a++) begin
      m = rnd_mat(); m[4*RW-1:0] = '0; m[a*8 +: 8] = 8'(a) | 8'h80;
      load_mat(m);
      run_op(1'b1, 1'b0, 1'b0, r1);
      chk(r1 == tr_quad(m), "R8 one-hot quad", r1, tr_quad(m));
    end

    // R8 / R9 random data, quad twice
    for (int t = 0; t < 8; t++) begin
      m = rnd_mat();
      load_mat(m);
      run_op(1'b1, 1'b0, 1'b0, r1);
      chk(r1 == tr_quad(m), "R8 random quad", r1, tr_quad(m));
      run_op(1'b1, 1'b0, 1'b0, r2);
      chk(r2 == m, "R9 quad twice", r2, m);
    end

    // R4 loads during busy ignored
    m = rnd_mat();
    load_mat(m);
    run_op(1'b0, 1'b1, 1'b0, r1);
    chk(r1 == tr_full(m), "R4 load while busy full", r1, tr_full(m));
    m = rnd_mat();
    load_mat(m);
    run_op(1'b1, 1'b1, 1'b0, r1);
    chk(r1 == tr_quad(m), "R4 load while busy quad", r1, tr_quad(m));

    // R10 start while busy ignored, mode held from accepted start
    m = rnd_mat();
    load_mat(m);
    run_op(1'b0, 1'b0, 1'b1, r1);
    chk(r1 == tr_full(m), "R10 restart ignored full", r1, tr_full(m));
    m = rnd_mat();
    load_mat(m);
    run_op(1'b1, 1'b0, 1'b1, r1);
    chk(r1 == tr_quad(m), "R10 restart ignored quad", r1, tr_quad(m));

    // R11 result holds after done
    repeat (4) @(negedge clk_i);
    chk(mat_o == tr_quad(m), "R11 result hold", mat_o, tr_quad(m));

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule